// File: doc/BRIEF.md
# Two-Mode Shared Arithmetic Pipeline

This block evaluates one of two fixed integer expressions over ten 16-bit operands, named a through j. A static mode bit picks the expression. Both expressions run on one pool of operator instances, with their inputs steered by the mode, and on one two-state controller that alternates between S0 and S1 on every clock. The pipeline takes a new operand set every second cycle and produces a new result every second cycle.

Every pipeline register loads on a controller state. The load enable of a shared register is the OR of one term per mode, and each term is a state decode ANDed with the mode. The operations are placed so that both modes load a shared register in the same state. Most enables therefore reduce to a plain state decode. Mode 1 finishes in three pipeline stages and mode 0 in four. The mode bit may change only while the pipeline is empty.

Top module: `dualexpr_pipe`

## Requirements
- R1: With mode_sel = 0 the result is ((a+b)*(c-d) + e*f - (g >> h)) * (i+j). Operand k sits at bits [16k+15:16k] of the operand bus, with a as k=0 through j as k=9.
- R2: With mode_sel = 1 the result is ((a*b) + (c-d) + (e+f)) * ((g+h)*(i-j)), using the same operand packing.
- R3: All arithmetic is unsigned and wraps modulo 2^16, including intermediate products and differences.
- R4: The right shift in mode 0 uses only the low 4 bits of h as the shift amount. The upper 12 bits of h have no effect.
- R5: The cycle right after reset is released is state S0, and the state then alternates S1, S0, and so on. An operand set is taken only when in_valid is high in an S0 cycle. in_valid in an S1 cycle is ignored and produces no result.
- R6: In mode 1, out_valid rises exactly 6 cycles after the cycle in which the operand set was accepted.
- R7: In mode 0, out_valid rises exactly 8 cycles after the cycle in which the operand set was accepted.
- R8: Operand sets offered in consecutive S0 cycles, one every 2 cycles, are all accepted. Their results appear in order, one every 2 cycles.
- R9: out_valid is high for a single cycle per result. result holds its value after that cycle until the next result.
- R10: A synchronous active-high reset sets the controller to S0 and clears every valid bit. Operand sets still in flight are dropped, and out_valid and result read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Expression select (0 or 1); change only while empty |
| in_valid | input | 1 | Operand set present; taken in S0 cycles |
| operands | input | 160 | Ten 16-bit operands, a at the lowest bits |
| result | output | 16 | Most recent result |
| out_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach is the controller phase, because no port shows it. The bench counts clock edges from the moment reset is released and offers operands only in slots that it computes to be S0 or S1. A mid-flight reset followed by a fresh transfer checks that the phase and the latency both restart from reset. Back-to-back sets at the 2-cycle rate in both modes keep the 3-stage and 4-stage pipelines full, so that any stage loading in the wrong state corrupts a neighbouring result.

// File: rtl/dualexpr_pkg.sv
package dualexpr_pkg;

    localparam int DW        = 16;
    localparam int NOPS      = 10;
    localparam int SHW       = $clog2(DW);
    localparam int DEPTH_M0  = 4;
    localparam int DEPTH_M1  = 3;
    localparam int DEPTH_MAX = (DEPTH_M0 > DEPTH_M1) ? DEPTH_M0 : DEPTH_M1;
    localparam int BUSW      = NOPS * DW;

    typedef logic [DW-1:0] word_t;

    typedef enum logic {
        ST_S0 = 1'b0,
        ST_S1 = 1'b1
    } cstate_t;

    // first stage: operands and one-cycle results
    typedef struct packed {
        word_t k0;
        word_t k1;
        word_t k2;
        word_t k3;
        word_t k4;
        word_t k5;
    } stg1_t;

    // second stage: products and carried terms
    typedef struct packed {
        word_t j0;
        word_t j1;
        word_t j2;
        word_t j3;
    } stg2_t;

    // third stage: combined term and carried factor
    typedef struct packed {
        word_t h0;
        word_t h1;
    } stg3_t;

    function automatic word_t opnd(input logic [BUSW-1:0] bus, input int idx);
        return bus[idx*DW +: DW];
    endfunction

endpackage

// File: rtl/dualexpr_ctrl.sv
module dualexpr_ctrl
    import dualexpr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_sel,
    input  logic                 in_valid,
    output cstate_t              cur_st,
    output logic [DEPTH_MAX-1:0] ld_stage,
    output logic [DEPTH_MAX-1:0] vld,
    output logic                 ld_out,
    output logic                 out_valid
);

    logic last_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_st <= ST_S0;
        end else begin
            cur_st <= (cur_st == ST_S0) ? ST_S1 : ST_S0;
        end
    end

    for (genvar i = 0; i < DEPTH_MAX; i++) begin : g_stage
        localparam bit USE_M0 = (i < DEPTH_M0);
        localparam bit USE_M1 = (i < DEPTH_M1);

        // merged enable: one state-and-mode term per mode, ORed
        assign ld_stage[i] = ((cur_st == ST_S0) && !mode_sel && USE_M0)
                           || ((cur_st == ST_S0) &&  mode_sel && USE_M1);

        logic vld_in;
        if (i == 0) begin : g_head
            assign vld_in = in_valid;
        end else begin : g_link
            assign vld_in = vld[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vld[i] <= 1'b0;
            end else if (cur_st == ST_S0) begin
                vld[i] <= vld_in && (mode_sel ? USE_M1 : USE_M0);
            end
        end
    end

    assign last_vld = mode_sel ? vld[DEPTH_M1-1] : vld[DEPTH_M0-1];
    assign ld_out   = (cur_st == ST_S1) && last_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= ld_out;
        end
    end

endmodule

// File: rtl/dualexpr_front.sv
module dualexpr_front
    import dualexpr_pkg::*;
(
    input  logic            mode_sel,
    input  logic [BUSW-1:0] operands,
    output stg1_t           s1_d
);

    word_t va, vb, vc, vd, ve, vf, vg, vh, vi, vj;
    word_t add0, add1, sub0, sub1, shr;

    assign va = opnd(operands, 0);
    assign vb = opnd(operands, 1);
    assign vc = opnd(operands, 2);
    assign vd = opnd(operands, 3);
    assign ve = opnd(operands, 4);
    assign vf = opnd(operands, 5);
    assign vg = opnd(operands, 6);
    assign vh = opnd(operands, 7);
    assign vi = opnd(operands, 8);
    assign vj = opnd(operands, 9);

    // shared adders, inputs steered by mode
    assign add0 = mode_sel ? (vg + vh) : (va + vb);
    assign add1 = mode_sel ? (ve + vf) : (vi + vj);
    // same sources in both modes: no steering
    assign sub0 = vc - vd;
    assign sub1 = vi - vj;
    assign shr  = vg >> vh[SHW-1:0];

    always_comb begin
        s1_d.k0 = add0;
        s1_d.k1 = sub0;
        s1_d.k2 = mode_sel ? va : ve;
        s1_d.k3 = mode_sel ? vb : vf;
        s1_d.k4 = add1;
        s1_d.k5 = mode_sel ? sub1 : shr;
    end

endmodule

// File: rtl/dualexpr_mid.sv
module dualexpr_mid
    import dualexpr_pkg::*;
(
    input  logic  mode_sel,
    input  stg1_t s1_q,
    output stg2_t s2_d
);

    word_t mul0, mul1, add2;

    assign mul0 = s1_q.k0 * (mode_sel ? s1_q.k5 : s1_q.k1);
    assign mul1 = s1_q.k2 * s1_q.k3;
    assign add2 = s1_q.k1 + s1_q.k4;

    always_comb begin
        s2_d.j0 = mul0;
        s2_d.j1 = mul1;
        s2_d.j2 = mode_sel ? add2 : s1_q.k5;
        s2_d.j3 = s1_q.k4;
    end

endmodule

// File: rtl/dualexpr_tail.sv
module dualexpr_tail
    import dualexpr_pkg::*;
(
    input  logic  mode_sel,
    input  stg2_t s2_q,
    input  stg3_t s3_q,
    output stg3_t s3_d,
    output word_t s4_d
);

    word_t add3, sub2, mul_a, mul_b, prod;

    assign add3 = s2_q.j1 + (mode_sel ? s2_q.j2 : s2_q.j0);
    assign sub2 = add3 - s2_q.j2;

    // one multiplier serves stage 3 in mode 1 and stage 4 in mode 0
    assign mul_a = mode_sel ? add3    : s3_q.h0;
    assign mul_b = mode_sel ? s2_q.j0 : s3_q.h1;
    assign prod  = mul_a * mul_b;

    always_comb begin
        s3_d.h0 = mode_sel ? prod : sub2;
        s3_d.h1 = s2_q.j3;
    end

    assign s4_d = prod;

endmodule

// File: rtl/dualexpr_pipe.sv
module dualexpr_pipe
    import dualexpr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_sel,
    input  logic            in_valid,
    input  logic [BUSW-1:0] operands,
    output logic [DW-1:0]   result,
    output logic            out_valid
);

    cstate_t              cur_st;
    logic [DEPTH_MAX-1:0] ld_stage;
    logic [DEPTH_MAX-1:0] vld;
    logic                 ld_out;

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;
    stg3_t s3_d, s3_q;
    word_t s4_d, s4_q;
    word_t res_q;

    dualexpr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .in_valid (in_valid),
        .cur_st   (cur_st),
        .ld_stage (ld_stage),
        .vld      (vld),
        .ld_out   (ld_out),
        .out_valid(out_valid)
    );

    dualexpr_front u_front (
        .mode_sel(mode_sel),
        .operands(operands),
        .s1_d    (s1_d)
    );

    dualexpr_mid u_mid (
        .mode_sel(mode_sel),
        .s1_q    (s1_q),
        .s2_d    (s2_d)
    );

    dualexpr_tail u_tail (
        .mode_sel(mode_sel),
        .s2_q    (s2_q),
        .s3_q    (s3_q),
        .s3_d    (s3_d),
        .s4_d    (s4_d)
    );

    always_ff @(posedge clk) begin
        if (ld_stage[0]) s1_q <= s1_d;
        if (ld_stage[1]) s2_q <= s2_d;
        if (ld_stage[2]) s3_q <= s3_d;
        if (ld_stage[3]) s4_q <= s4_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (ld_out) begin
            res_q <= mode_sel ? s3_q.h0 : s4_q;
        end
    end

    assign result = res_q;

endmodule

// File: rtl/dualexpr_chk.sv
module dualexpr_chk
    import dualexpr_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 mode_sel,
    input logic                 in_valid,
    input logic                 out_valid,
    input cstate_t              cur_st,
    input logic [DEPTH_MAX-1:0] vld
);

    // mode 1 result comes 6 cycles after an S0 acceptance
    assert_lat_m1_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_sel) |-> $past(in_valid && cur_st == ST_S0, 6));

    // mode 0 result comes 8 cycles after an S0 acceptance
    assert_lat_m0_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mode_sel) |-> $past(in_valid && cur_st == ST_S0, 8));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_s1_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_st == ST_S1) |=> $stable(vld));

    assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && vld == '0 && cur_st == ST_S0));

endmodule

bind dualexpr_pipe dualexpr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .cur_st   (cur_st),
    .vld      (vld)
);

// File: tb/dualexpr_pipe_tb.sv
module dualexpr_pipe_tb;

    localparam int CLK_PERIOD = 10;
    localparam int OPW = 16;
    localparam int NOP = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               mode_sel = 1'b0;
    logic               in_valid = 1'b0;
    logic [NOP*OPW-1:0] operands = '0;
    logic [OPW-1:0]     result;
    logic               out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_cnt = 0;
    bit finished = 1'b0;

    dualexpr_pipe u_dut (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .in_valid (in_valid),
        .operands (operands),
        .result   (result),
        .out_valid(out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // posedges since reset release; an even count means the next edge ends an S0 cycle
    always @(posedge clk) begin
        if (rst) edge_cnt <= 0;
        else     edge_cnt <= edge_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input logic [OPW-1:0] act,
                         input logic [OPW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    function automatic logic [NOP*OPW-1:0] pack(
        input logic [OPW-1:0] a, b, c, d, e, f, g, h, i, j);
        return {j, i, h, g, f, e, d, c, b, a};
    endfunction

    function automatic logic [OPW-1:0] model(input logic m, input logic [NOP*OPW-1:0] bus);
        logic [OPW-1:0] a, b, c, d, e, f, g, h, i, j, r;
        a = bus[0*OPW +: OPW]; b = bus[1*OPW +: OPW];
        c = bus[2*OPW +: OPW]; d = bus[3*OPW +: OPW];
        e = bus[4*OPW +: OPW]; f = bus[5*OPW +: OPW];
        g = bus[6*OPW +: OPW]; h = bus[7*OPW +: OPW];
        i = bus[8*OPW +: OPW]; j = bus[9*OPW +: OPW];
        if (!m) r = ((a + b) * (c - d) + e * f - (g >> h[3:0])) * (i + j);
        else    r = ((a * b) + (c - d) + (e + f)) * ((g + h) * (i - j));
        return r;
    endfunction

    task automatic wait_slot(input bit want_s1);
        @(negedge clk);
        while ((edge_cnt % 2) != (want_s1 ? 1 : 0)) @(negedge clk);
    endtask

    // one operand set, exact latency, pulse width and hold
    task automatic run_one(input logic m, input logic [NOP*OPW-1:0] bus, input string req);
        int lat;
        logic [OPW-1:0] exp;
        lat = m ? 6 : 8;
        exp = model(m, bus);
        mode_sel = m;
        wait_slot(1'b0);
        operands = bus;
        in_valid = 1'b1;
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (k < lat) begin
                check(out_valid == 1'b0, {req, " early out_valid"}, {15'd0, out_valid}, 16'd0);
            end else if (k == lat) begin
                check(out_valid == 1'b1, {req, " out_valid at latency"}, {15'd0, out_valid}, 16'd1);
                check(result == exp, {req, " result"}, result, exp);
            end else begin
                check(out_valid == 1'b0, "R9 pulse width", {15'd0, out_valid}, 16'd0);
                check(result == exp, "R9 result hold", result, exp);
            end
        end
    endtask

    task automatic test_reset_state;
        check(out_valid == 1'b0, "R10 reset out_valid", {15'd0, out_valid}, 16'd0);
        check(result == 16'd0, "R10 reset result", result, 16'd0);
    endtask

    task automatic test_mode0;
        run_one(1'b0, pack(16'd3, 16'd4, 16'd10, 16'd2, 16'd5, 16'd6, 16'd64, 16'd2,
                           16'd1, 16'd2), "R1 R7");
        run_one(1'b0, pack(16'd100, 16'd23, 16'd50, 16'd7, 16'd9, 16'd11, 16'd1000, 16'd0,
                           16'd3, 16'd4), "R1 R7 mode0 second");
    endtask

    task automatic test_mode1;
        run_one(1'b1, pack(16'd3, 16'd4, 16'd10, 16'd2, 16'd5, 16'd6, 16'd7, 16'd8,
                           16'd9, 16'd1), "R2 R6");
        run_one(1'b1, pack(16'd12, 16'd13, 16'd200, 16'd99, 16'd1, 16'd2, 16'd30, 16'd40,
                           16'd77, 16'd70), "R2 R6 mode1 second");
    endtask

    task automatic test_wrap;
        run_one(1'b0, pack(16'hFFF0, 16'h0123, 16'h0005, 16'h9000, 16'hABCD, 16'h4321,
                           16'hF00F, 16'h0001, 16'hFFFF, 16'h0003), "R3 mode0 wrap");
        run_one(1'b1, pack(16'hBEEF, 16'hCAFE, 16'h0001, 16'hFFFF, 16'h8000, 16'h8001,
                           16'hF000, 16'h2000, 16'h0002, 16'h7777), "R3 mode1 wrap");
    endtask

    task automatic test_shift;
        // upper bits of h set: only 3 and 0 take effect
        run_one(1'b0, pack(16'd1, 16'd1, 16'd9, 16'd1, 16'd2, 16'd2, 16'h8000, 16'hFF13,
                           16'd1, 16'd1), "R4 shift low bits");
        run_one(1'b0, pack(16'd1, 16'd1, 16'd9, 16'd1, 16'd2, 16'd2, 16'h00F0, 16'hABC0,
                           16'd1, 16'd1), "R4 shift zero");
    endtask

    task automatic test_s1_ignored;
        mode_sel = 1'b1;
        wait_slot(1'b1);
        operands = pack(16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8, 16'd9, 16'd1);
        in_valid = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == 1'b0, "R5 S1 input ignored", {15'd0, out_valid}, 16'd0);
        end
    endtask

    task automatic test_back_to_back(input logic m);
        logic [NOP*OPW-1:0] bus [3];
        logic [OPW-1:0]     exp [3];
        int lat;
        lat = m ? 6 : 8;
        bus[0] = pack(16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8, 16'd9, 16'd10);
        bus[1] = pack(16'd21, 16'd5, 16'd40, 16'd1, 16'd3, 16'd3, 16'd512, 16'd4, 16'd11, 16'd2);
        bus[2] = pack(16'hFFFF, 16'd7, 16'd2, 16'd9, 16'd300, 16'd301, 16'd99, 16'd1, 16'd5, 16'd6);
        for (int s = 0; s < 3; s++) exp[s] = model(m, bus[s]);
        mode_sel = m;
        wait_slot(1'b0);
        operands = bus[0];
        in_valid = 1'b1;
        for (int k = 1; k <= lat + 5; k++) begin
            @(negedge clk);
            if (k == 2 || k == 4) begin
                operands = bus[k/2];
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            if (k >= lat && ((k - lat) % 2 == 0) && ((k - lat) / 2 < 3)) begin
                check(out_valid == 1'b1, "R8 back-to-back valid", {15'd0, out_valid}, 16'd1);
                check(result == exp[(k - lat) / 2], "R8 back-to-back result", result,
                      exp[(k - lat) / 2]);
            end else begin
                check(out_valid == 1'b0, "R8 back-to-back gap", {15'd0, out_valid}, 16'd0);
            end
        end
    endtask

    task automatic test_midflight_reset;
        mode_sel = 1'b0;
        wait_slot(1'b0);
        operands = pack(16'd9, 16'd9, 16'd9, 16'd1, 16'd2, 16'd3, 16'd4, 16'd1, 16'd5, 16'd5);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R10 out_valid after reset", {15'd0, out_valid}, 16'd0);
        check(result == 16'd0, "R10 result after reset", result, 16'd0);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R10 in-flight set dropped", {15'd0, out_valid}, 16'd0);
        end
        // phase restarts at S0 after release: latency must hold again
        run_one(1'b1, pack(16'd2, 16'd3, 16'd4, 16'd1, 16'd1, 16'd1, 16'd2, 16'd2, 16'd5, 16'd3),
                "R5 R6 after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset_state();
        test_mode0();
        test_mode1();
        test_wrap();
        test_shift();
        test_s1_ignored();
        test_back_to_back(1'b1);
        test_back_to_back(1'b0);
        test_midflight_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule